// File: doc/BRIEF.md
# Scan Reset and Set Self-Test Sequencer

This block drives a scan chain through a short, fixed routine that proves every flop's reset or set pin actually works. Pattern generation cannot cover these pins, because the chain reset is held inactive while generated patterns are applied. The sequencer shifts a solid field of ones into the chain and then pulses the chain reset. It shifts the chain out while zeros flow in behind, pulses the reset a second time and shifts out once more. It compares every bit it receives against the value that bit's flop should take on reset.

The caller gives the controller a per-flop polarity vector. A 0 marks a flop that clears on reset and a 1 marks a flop that presets. Both unloads are compared against this vector. A flop whose reset or set pin is dead keeps the value that was loaded, so the ones load exposes dead clear pins and the zeros load exposes dead preset pins. The first mismatch is latched together with its bit position. When the run finishes, the chain reset is left inactive and the block reports done, so that normal pattern application can take over. A mode input selects chains whose flops reset synchronously. In that mode the controller also enables one chain clock while the reset is still asserted.

Top module: `scan_rst_sequencer`

## Requirements
- R1: Out of controller reset, done, pass and failValid are 0, scanEnable and chainClkEn are 0, and chainRstN (active low) is 1.
- R2: On the clock edge that samples start high in the idle or done state, a run begins. For the next CHAIN_LEN cycles scanEnable=1, chainClkEn=1 and scanIn=1, so the chain fills with ones.
- R3: Each reset pulse holds chainRstN=0 and scanEnable=0 for RST_CYCLES cycles. In asynchronous mode (syncMode=0) chainClkEn stays 0 for the whole pulse.
- R4: With syncMode=1, chainClkEn is 1 on exactly the last cycle of each reset pulse and 0 on the other pulse cycles. scanEnable is never 1 while chainRstN is 0.
- R5: After the first pulse, the chain is unloaded over CHAIN_LEN cycles with scanEnable=1, chainClkEn=1 and scanIn=0. On the k-th unload cycle (k counted from 0), scanOut is compared with polMask bit CHAIN_LEN-1-k.
- R6: A second pulse of the same form follows. A second unload then compares scanOut in the same order, again with scanIn=0.
- R7: After the second unload there is one cycle with chainRstN=1, scanEnable=0 and chainClkEn=0. After that, done=1 and the same outputs are held until the next start. pass=1 only when done=1 and no mismatch was seen.
- R8: The first mismatch sets failValid and stores its bit index in failIndex. Both stay unchanged through later mismatches, and both are cleared when the next run starts.
- R9: start is ignored while a run is in progress.
- R10: polMask and syncMode are captured when the run starts. Changing them during the run has no effect on the outputs or on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and chain clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller |
| start | input | 1 | Launches a run when idle or done |
| syncMode | input | 1 | 1 selects chains with synchronous reset flops |
| polMask | input | CHAIN_LEN | Expected post-reset value of each flop, with bit 0 nearest scanIn |
| scanOut | input | 1 | Serial output of the chain's last flop |
| scanIn | output | 1 | Serial data into the chain |
| scanEnable | output | 1 | Shift enable of the chain |
| chainRstN | output | 1 | Active-low reset driven to the chain |
| chainClkEn | output | 1 | Clock enable for the chain |
| done | output | 1 | Run complete; chain reset released |
| pass | output | 1 | Run complete with no mismatch |
| failValid | output | 1 | A mismatch has been seen in this run |
| failIndex | output | IDX_W | Bit index of the first mismatch |

## Verification
The hardest case to reach from the ports is a flop whose reset or set pin is broken. A correct chain never produces one. The bench therefore models the chain itself, with a defect mask of flops that ignore reset. It also checks that a failing index survives a later mismatch, which needs two defective flops whose faults show up in the same unload. A second hard case is a controller left in asynchronous mode against a chain that resets only synchronously. That run can fail only through the missing clock during the pulse. Every output is compared cycle by cycle against the expected phase schedule.

// File: rtl/scan_rst_pkg.sv
package scan_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD1,
    ST_PULSE1,
    ST_UNLOAD1,
    ST_PULSE2,
    ST_UNLOAD2,
    ST_RELEASE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic clrCnt;   // restart the phase counter
    logic incCnt;   // advance the phase counter
    logic cmpEn;    // compare scanOut this cycle
    logic capture;  // latch run inputs, clear verdict
  } dpStrobe_t;

endpackage

// File: rtl/scan_rst_datapath.sv
module scan_rst_datapath
  import scan_rst_pkg::*;
#(
  parameter int CHAIN_LEN  = 8,
  parameter int RST_CYCLES = 2,
  parameter int IDX_W      = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [CHAIN_LEN-1:0] polMask,
  input  logic                 scanOut,
  output logic                 shiftLast,
  output logic                 pulseLast,
  output logic                 failValid,
  output logic [IDX_W-1:0]     failIndex
);

  localparam int CNT_MAX = (CHAIN_LEN > RST_CYCLES) ? CHAIN_LEN : RST_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]     cnt;
  logic [CHAIN_LEN-1:0] maskReg;
  logic [IDX_W-1:0]     bitSel;
  logic                 mismatch;

  assign shiftLast = (cnt == CNT_W'(CHAIN_LEN - 1));
  assign pulseLast = (cnt == CNT_W'(RST_CYCLES - 1));
  // Unload order: last flop first.
  assign bitSel    = IDX_W'(CNT_W'(CHAIN_LEN - 1) - cnt);
  assign mismatch  = (scanOut != maskReg[bitSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (strobe.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= '0;
      failValid <= 1'b0;
      failIndex <= '0;
    end else if (strobe.capture) begin
      maskReg   <= polMask;
      failValid <= 1'b0;
      failIndex <= '0;
    end else if (strobe.cmpEn && mismatch && !failValid) begin
      failValid <= 1'b1;
      failIndex <= bitSel;
    end
  end

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (failValid && !strobe.capture) |=> (failValid && $stable(failIndex)));

  assert_cmp_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpEn |-> (cnt < CNT_W'(CHAIN_LEN)));

endmodule

// File: rtl/scan_rst_ctrl.sv
module scan_rst_ctrl
  import scan_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      syncMode,
  input  logic      shiftLast,
  input  logic      pulseLast,
  input  logic      failValid,
  output dpStrobe_t strobe,
  output logic      scanIn,
  output logic      scanEnable,
  output logic      chainRstN,
  output logic      chainClkEn,
  output logic      done,
  output logic      pass
);

  seqState_t state, nextState;
  logic      syncReg;
  logic      launch;

  assign launch = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      syncReg <= 1'b0;
    end else begin
      state <= nextState;
      if (launch) syncReg <= syncMode;
    end
  end

  always_comb begin
    nextState  = state;
    strobe     = '0;
    scanIn     = 1'b0;
    scanEnable = 1'b0;
    chainRstN  = 1'b1;
    chainClkEn = 1'b0;
    done       = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        done = (state == ST_DONE);
        if (launch) begin
          nextState      = ST_LOAD1;
          strobe.clrCnt  = 1'b1;
          strobe.capture = 1'b1;
        end
      end
      ST_LOAD1: begin
        scanEnable    = 1'b1;
        chainClkEn    = 1'b1;
        scanIn        = 1'b1;
        strobe.incCnt = 1'b1;
        if (shiftLast) begin
          nextState     = ST_PULSE1;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_PULSE1, ST_PULSE2: begin
        chainRstN     = 1'b0;
        chainClkEn    = syncReg && pulseLast;
        strobe.incCnt = 1'b1;
        if (pulseLast) begin
          nextState     = (state == ST_PULSE1) ? ST_UNLOAD1 : ST_UNLOAD2;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_UNLOAD1, ST_UNLOAD2: begin
        scanEnable    = 1'b1;
        chainClkEn    = 1'b1;
        strobe.incCnt = 1'b1;
        strobe.cmpEn  = 1'b1;
        if (shiftLast) begin
          nextState     = (state == ST_UNLOAD1) ? ST_PULSE2 : ST_RELEASE;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_RELEASE: nextState = ST_DONE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign pass = done && !failValid;

  assert_no_shift_in_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    scanEnable |-> chainRstN);

  assert_clock_in_pulse_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chainClkEn && !chainRstN) |-> syncReg);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chainRstN && !scanEnable && !chainClkEn));

  assert_release_to_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE) |=> done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != ST_IDLE && state != ST_DONE && state != ST_UNLOAD2)
      |=> (state != ST_LOAD1 || $past(state) == ST_LOAD1));

endmodule

// File: rtl/scan_rst_sequencer.sv
module scan_rst_sequencer
  import scan_rst_pkg::*;
#(
  parameter int CHAIN_LEN  = 8,
  parameter int RST_CYCLES = 2,
  parameter int IDX_W      = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 syncMode,
  input  logic [CHAIN_LEN-1:0] polMask,
  input  logic                 scanOut,
  output logic                 scanIn,
  output logic                 scanEnable,
  output logic                 chainRstN,
  output logic                 chainClkEn,
  output logic                 done,
  output logic                 pass,
  output logic                 failValid,
  output logic [IDX_W-1:0]     failIndex
);

  dpStrobe_t strobe;
  logic      shiftLast;
  logic      pulseLast;

  scan_rst_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .syncMode   (syncMode),
    .shiftLast  (shiftLast),
    .pulseLast  (pulseLast),
    .failValid  (failValid),
    .strobe     (strobe),
    .scanIn     (scanIn),
    .scanEnable (scanEnable),
    .chainRstN  (chainRstN),
    .chainClkEn (chainClkEn),
    .done       (done),
    .pass       (pass)
  );

  scan_rst_datapath #(
    .CHAIN_LEN  (CHAIN_LEN),
    .RST_CYCLES (RST_CYCLES),
    .IDX_W      (IDX_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .polMask   (polMask),
    .scanOut   (scanOut),
    .shiftLast (shiftLast),
    .pulseLast (pulseLast),
    .failValid (failValid),
    .failIndex (failIndex)
  );

endmodule

// File: tb/test_scan_rst_sequencer.sv
module test_scan_rst_sequencer;

  localparam int N  = 8;
  localparam int R  = 2;
  localparam int IW = 3;
  localparam int RUN_LEN = 3 * N + 2 * R + 1;

  typedef struct packed {
    logic [N-1:0]  mask;
    logic [N-1:0]  brk;
    logic          sync;
    logic          expPass;
    logic [IW-1:0] expIdx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 8'h00, 1'b0, 1'b1, 3'd0},
    '{8'hFF, 8'h00, 1'b1, 1'b1, 3'd0},
    '{8'hA5, 8'h00, 1'b0, 1'b1, 3'd0},
    '{8'h00, 8'h08, 1'b0, 1'b0, 3'd3},
    '{8'hFF, 8'h41, 1'b1, 1'b0, 3'd6},
    '{8'h0F, 8'h81, 1'b0, 1'b0, 3'd7},
    '{8'h3C, 8'h24, 1'b1, 1'b0, 3'd5},
    '{8'h5A, 8'h05, 1'b0, 1'b0, 3'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic syncMode = 1'b0;
  logic [N-1:0] polMask = '0;
  logic scanOut;
  logic scanIn, scanEnable, chainRstN, chainClkEn, done, pass, failValid;
  logic [IW-1:0] failIndex;

  // chain model
  logic [N-1:0] chain = '0;
  logic [N-1:0] chainMask = '0;
  logic [N-1:0] brkMask = '0;
  logic chainSyncModel = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scan_rst_sequencer #(.CHAIN_LEN(N), .RST_CYCLES(R)) i_scan_rst_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .syncMode(syncMode),
    .polMask(polMask), .scanOut(scanOut), .scanIn(scanIn),
    .scanEnable(scanEnable), .chainRstN(chainRstN), .chainClkEn(chainClkEn),
    .done(done), .pass(pass), .failValid(failValid), .failIndex(failIndex)
  );

  assign scanOut = chain[N-1];

  always @(posedge clk) begin
    if (!chainRstN) begin
      if (!chainSyncModel || chainClkEn)
        chain <= (chainMask & ~brkMask) | (chain & brkMask);
    end else if (chainClkEn && scanEnable) begin
      chain <= {chain[N-2:0], scanIn};
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // One full run, outputs checked every cycle against the phase schedule.
  task automatic runSeq(input logic [N-1:0] mask, input logic [N-1:0] brk,
                        input logic ctrlSync, input logic modelSync,
                        input bit disturb, input logic expPass,
                        input logic [IW-1:0] expIdx);
    @(negedge clk);
    polMask = mask; chainMask = mask; brkMask = brk;
    syncMode = ctrlSync; chainSyncModel = modelSync; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 verdict cleared at start", failValid, 0);
    for (int c = 0; c < RUN_LEN; c++) begin
      logic [3:0] exp;
      string req;
      if (c < N)               begin exp = 4'b1111; req = "R2 load ones"; end
      else if (c < N + R)      begin exp = {3'b000, ctrlSync && (c == N + R - 1)};
                                     req = ctrlSync ? "R4 pulse1 sync" : "R3 pulse1"; end
      else if (c < 2 * N + R)  begin exp = 4'b1101; req = "R5 unload1"; end
      else if (c < 2 * N + 2 * R) begin exp = {3'b000, ctrlSync && (c == 2 * N + 2 * R - 1)};
                                     req = ctrlSync ? "R4 pulse2 sync" : "R3 pulse2"; end
      else if (c < 3 * N + 2 * R) begin exp = 4'b1101; req = "R6 unload2"; end
      else                     begin exp = 4'b0100; req = "R7 release"; end
      if (disturb) req = {req, " R9 R10"};
      check(req, {scanEnable, chainRstN, scanIn, chainClkEn}, exp);
      if (disturb && c == 4) begin
        start = 1'b1; polMask = ~mask; syncMode = ~ctrlSync;
      end
      if (disturb && c == 5) start = 1'b0;
      @(negedge clk);
    end
    check("R7 done", done, 1);
    check("R7 pass", pass, expPass);
    check("R8 failValid", failValid, !expPass);
    if (!expPass) check("R8 failIndex", failIndex, expIdx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    check("R1 failValid", failValid, 0);
    check("R1 outputs", {scanEnable, chainRstN, chainClkEn}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {done, scanEnable, chainRstN, chainClkEn}, 4'b0010);

    foreach (VECS[i])
      runSeq(VECS[i].mask, VECS[i].brk, VECS[i].sync, VECS[i].sync, 1'b0,
             VECS[i].expPass, VECS[i].expIdx);

    // R7: done and quiet outputs held
    repeat (4) @(negedge clk);
    check("R7 done held", {done, scanEnable, chainRstN, chainClkEn}, 4'b1010);

    // R4: asynchronous controller mode on a synchronous chain leaves it unreset
    runSeq(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd7);

    // R8: verdict cleared by a following clean run
    runSeq(8'hC3, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0);

    // R9, R10: start, mask and mode disturbed mid-run
    runSeq(8'h0F, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    runSeq(8'h96, 8'h10, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule